// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block runs the memory cycles of four stack instructions for an 8-bit CPU with a 16-bit address bus:
- software interrupt entry, which stacks the full register context and fetches a vector;
- return from interrupt, which unstacks the full context;
- return from subroutine;
- pull of the IY index register.

A single-cycle `start` command carries the opcode and the current register state:
- the opcode, with a flag for the `$18` page prefix;
- the stack pointer and the opcode address;
- the condition code register, the A and B accumulators, and the IX and IY index registers.

From then on the block drives the same address, read/write and write-data pattern on every cycle that the CPU itself would produce, dummy cycles included. It captures the read data it needs into register outputs.

When the last cycle ends, the block raises `done` for one cycle. At that point it presents the final stack pointer, the new program counter and the restored registers. An opcode outside the four supported ones raises `err` for one cycle and makes no bus cycle.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `rw` is 1, `addr` is 16'hFFFF and `wdata` is 0. The same bus values hold whenever the block is idle.
- R2: Opcode decode works as follows:
  - `page`=0 with `opcode` 8'h3F is a software interrupt.
  - `page`=0 with 8'h3B is a return from interrupt.
  - `page`=0 with 8'h39 is a return from subroutine.
  - `page`=1 with 8'h38 is a pull of IY.
  - Any other pair raises `err` for exactly one cycle, leaves `busy` low and drives no bus cycle.
- R3: A software interrupt takes 14 bus cycles. Cycle n drives the following, with `rw` low only in cycles 3 to 11:
  - cycles 1-2: PC+n-1;
  - cycles 3-11: SP-(n-3);
  - cycle 12: SP-8;
  - cycle 13: VEC_ADDR;
  - cycle 14: VEC_ADDR+1.
- R4: In its write cycles 3 to 11, a software interrupt stacks these bytes in this order: (PC+1) low, (PC+1) high, IY low, IY high, IX low, IX high, A, B, CCR.
- R5: At `done` after a software interrupt, `pc_out` is {read of cycle 13, read of cycle 14} and `sp_out` is SP-9.
- R6: A return from interrupt makes 12 reads. Cycles 1-2 address PC+n-1 and cycles 3-12 address SP+(n-3). The reads of cycles 4 to 12 load, in order: CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low. `sp_out` becomes SP+9.
- R7: A return from subroutine makes 5 reads, at PC, PC+1, SP, SP+1 and SP+2. The last two load `pc_out` high and then low. `sp_out` becomes SP+2.
- R8: A pull of IY makes 6 reads, at PC, PC+1, PC+2, SP, SP+1 and SP+2. The last two load `iy_out` high and then low. `sp_out` becomes SP+2 and `pc_out` becomes PC+2.
- R9: Any register an instruction does not restore keeps, at `done`, the value it had on the `start` inputs. Input changes after the start cycle have no effect.
- R10: `done` is a one-cycle pulse in the cycle after the last bus cycle. In that same cycle `busy` falls.
- R11: A `start` while `busy` is high is ignored, and the running sequence goes on unchanged.
- R12: Bus outputs are registered: bus cycle 1 appears in the cycle after the `start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, sampled when idle |
| page | input | 1 | Opcode carries the $18 page prefix |
| opcode | input | 8 | Opcode byte after any prefix |
| sp_in | input | 16 | Stack pointer at start |
| pc_in | input | 16 | Address of the first opcode byte |
| ccr_in | input | 8 | Condition code register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ix_in | input | 16 | Index register X |
| iy_in | input | 16 | Index register Y |
| rdata | input | 8 | Read data for the current bus cycle |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-opcode pulse |
| sp_out | output | 16 | Final stack pointer |
| pc_out | output | 16 | New program counter |
| ccr_out | output | 8 | Condition code register result |
| a_out | output | 8 | Accumulator A result |
| b_out | output | 8 | Accumulator B result |
| ix_out | output | 16 | Index X result |
| iy_out | output | 16 | Index Y result |

## Verification
The bench builds the block with `VEC_ADDR` = 16'hFFFF. This places the second vector fetch of a software interrupt at address 16'h0000, so the wrap of the vector address is checked on every interrupt entry. Stack pointers are drawn at random and also set by hand near both ends of the address space. This brings the wrap of the descending push and of the ascending pull sequences within reach, in addition to the mid-memory case.

// File: rtl/stack_frame_seq.sv
module stack_frame_seq #(
  parameter logic [15:0] VEC_ADDR = 16'hFFF6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        page,
  input  logic [7:0]  opcode,
  input  logic [15:0] sp_in,
  input  logic [15:0] pc_in,
  input  logic [7:0]  ccr_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [15:0] ix_in,
  input  logic [15:0] iy_in,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        rw,
  output logic [7:0]  wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] sp_out,
  output logic [15:0] pc_out,
  output logic [7:0]  ccr_out,
  output logic [7:0]  a_out,
  output logic [7:0]  b_out,
  output logic [15:0] ix_out,
  output logic [15:0] iy_out
);

  typedef enum logic [2:0] {K_NONE, K_SWI, K_RTI, K_RTS, K_PULY} kind_t;

  kind_t       kind_q, dec;
  logic [3:0]  cyc, nxt, last;
  logic [15:0] pc_q, sp_q;

  assign dec = (!page && opcode == 8'h3F) ? K_SWI :
               (!page && opcode == 8'h3B) ? K_RTI :
               (!page && opcode == 8'h39) ? K_RTS :
               ( page && opcode == 8'h38) ? K_PULY : K_NONE;

  assign last = (kind_q == K_SWI) ? 4'd14 :
                (kind_q == K_RTI) ? 4'd12 :
                (kind_q == K_RTS) ? 4'd5  : 4'd6;

  assign nxt = cyc + 4'd1;

  function automatic logic [15:0] addr_of(kind_t k, logic [3:0] c,
                                          logic [15:0] pc, logic [15:0] sp);
    logic [15:0] cc;
    cc = {12'd0, c};
    case (k)
      K_SWI: begin
        if (c <= 4'd2)       return pc + cc - 16'd1;
        else if (c <= 4'd11) return sp - (cc - 16'd3);
        else if (c == 4'd12) return sp - 16'd8;
        else if (c == 4'd13) return VEC_ADDR;
        else                 return VEC_ADDR + 16'd1;
      end
      K_PULY: begin
        if (c <= 4'd3) return pc + cc - 16'd1;
        else           return sp + cc - 16'd4;
      end
      default: begin
        if (c <= 4'd2) return pc + cc - 16'd1;
        else           return sp + cc - 16'd3;
      end
    endcase
  endfunction

  logic [15:0] ret;
  logic [7:0]  push_byte;
  assign ret = pc_q + 16'd1;

  always_comb begin
    case (nxt)
      4'd3:    push_byte = ret[7:0];
      4'd4:    push_byte = ret[15:8];
      4'd5:    push_byte = iy_out[7:0];
      4'd6:    push_byte = iy_out[15:8];
      4'd7:    push_byte = ix_out[7:0];
      4'd8:    push_byte = ix_out[15:8];
      4'd9:    push_byte = a_out;
      4'd10:   push_byte = b_out;
      4'd11:   push_byte = ccr_out;
      default: push_byte = 8'h00;
    endcase
  end

  logic nxt_write;
  assign nxt_write = (kind_q == K_SWI) && nxt >= 4'd3 && nxt <= 4'd11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_NONE;
      cyc     <= 4'd0;
      pc_q    <= 16'h0000;
      sp_q    <= 16'h0000;
      addr    <= 16'hFFFF;
      rw      <= 1'b1;
      wdata   <= 8'h00;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      sp_out  <= 16'h0000;
      pc_out  <= 16'h0000;
      ccr_out <= 8'h00;
      a_out   <= 8'h00;
      b_out   <= 8'h00;
      ix_out  <= 16'h0000;
      iy_out  <= 16'h0000;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (dec == K_NONE) begin
            err <= 1'b1;
          end else begin
            busy    <= 1'b1;
            kind_q  <= dec;
            cyc     <= 4'd1;
            pc_q    <= pc_in;
            sp_q    <= sp_in;
            addr    <= pc_in;
            rw      <= 1'b1;
            wdata   <= 8'h00;
            pc_out  <= pc_in + ((dec == K_PULY) ? 16'd2 : 16'd1);
            ccr_out <= ccr_in;
            a_out   <= a_in;
            b_out   <= b_in;
            ix_out  <= ix_in;
            iy_out  <= iy_in;
          end
        end
      end else begin
        case (kind_q)
          K_SWI: begin
            if (cyc == 4'd13) pc_out[15:8] <= rdata;
            if (cyc == 4'd14) pc_out[7:0]  <= rdata;
          end
          K_RTI: begin
            case (cyc)
              4'd4:  ccr_out      <= rdata;
              4'd5:  b_out        <= rdata;
              4'd6:  a_out        <= rdata;
              4'd7:  ix_out[15:8] <= rdata;
              4'd8:  ix_out[7:0]  <= rdata;
              4'd9:  iy_out[15:8] <= rdata;
              4'd10: iy_out[7:0]  <= rdata;
              4'd11: pc_out[15:8] <= rdata;
              4'd12: pc_out[7:0]  <= rdata;
              default: ;
            endcase
          end
          K_RTS: begin
            if (cyc == 4'd4) pc_out[15:8] <= rdata;
            if (cyc == 4'd5) pc_out[7:0]  <= rdata;
          end
          K_PULY: begin
            if (cyc == 4'd5) iy_out[15:8] <= rdata;
            if (cyc == 4'd6) iy_out[7:0]  <= rdata;
          end
          default: ;
        endcase
        if (cyc == last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          addr   <= 16'hFFFF;
          rw     <= 1'b1;
          wdata  <= 8'h00;
          sp_out <= (kind_q == K_SWI) ? sp_q - 16'd9 :
                    (kind_q == K_RTI) ? sp_q + 16'd9 : sp_q + 16'd2;
        end else begin
          cyc   <= nxt;
          addr  <= addr_of(kind_q, nxt, pc_q, sp_q);
          rw    <= !nxt_write;
          wdata <= nxt_write ? push_byte : 8'h00;
        end
      end
    end
  end

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rw && addr == 16'hFFFF)); // R1
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && rw)); // R2
  AST_WRITE_ONLY_SWI: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> (busy && kind_q == K_SWI)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc != last) |=> (busy && $stable(kind_q) && cyc == $past(cyc) + 4'd1)); // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err || $past(start)); // R2

endmodule

// File: tb/tb_stack_frame_seq.sv
module tb_stack_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TB_VEC = 16'hFFFF;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, page = 1'b0;
  logic [7:0]  opcode = 8'h00, ccr_in = 8'h00, a_in = 8'h00, b_in = 8'h00, key = 8'h00;
  logic [15:0] sp_in = 16'h0000, pc_in = 16'h0000, ix_in = 16'h0000, iy_in = 16'h0000;
  logic [7:0]  rdata, wdata, ccr_out, a_out, b_out;
  logic [15:0] addr, sp_out, pc_out, ix_out, iy_out;
  logic        rw, busy, done, err;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ key;
  endfunction
  assign rdata = pat(addr);

  stack_frame_seq #(.VEC_ADDR(TB_VEC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .opcode(opcode),
    .sp_in(sp_in), .pc_in(pc_in), .ccr_in(ccr_in), .a_in(a_in), .b_in(b_in),
    .ix_in(ix_in), .iy_in(iy_in), .rdata(rdata), .addr(addr), .rw(rw),
    .wdata(wdata), .busy(busy), .done(done), .err(err), .sp_out(sp_out),
    .pc_out(pc_out), .ccr_out(ccr_out), .a_out(a_out), .b_out(b_out),
    .ix_out(ix_out), .iy_out(iy_out));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // kind: 0 interrupt entry, 1 interrupt return, 2 subroutine return, 3 pull IY
  function automatic int ncyc(input int kind);
    case (kind) 0: return 14; 1: return 12; 2: return 5; default: return 6; endcase
  endfunction

  function automatic logic [15:0] eaddr(input int kind, input int n,
                                        input logic [15:0] pc, input logic [15:0] sp);
    if (kind == 0) begin
      if (n <= 2) return pc + 16'(n - 1);
      if (n <= 11) return sp - 16'(n - 3);
      if (n == 12) return sp - 16'd8;
      return (n == 13) ? TB_VEC : TB_VEC + 16'd1;
    end
    if (kind == 3) return (n <= 3) ? pc + 16'(n - 1) : sp + 16'(n - 4);
    return (n <= 2) ? pc + 16'(n - 1) : sp + 16'(n - 3);
  endfunction

  function automatic logic [7:0] ewd(input int n, input logic [15:0] pc, input logic [7:0] c,
                                     input logic [7:0] a, input logic [7:0] b,
                                     input logic [15:0] x, input logic [15:0] y);
    logic [15:0] r;
    r = pc + 16'd1;
    case (n)
      3: return r[7:0];   4: return r[15:8];
      5: return y[7:0];   6: return y[15:8];
      7: return x[7:0];   8: return x[15:8];
      9: return a;        10: return b;
      default: return c;
    endcase
  endfunction

  task automatic run_op(input int kind, input logic [15:0] sp, input logic [15:0] pc,
                        input bit poke);
    logic [7:0]  c, a, b;
    logic [15:0] x, y;
    logic [15:0] e_sp, e_pc, e_x, e_y;
    logic [7:0]  e_c, e_a, e_b;
    int n;
    n = ncyc(kind);
    c = 8'($urandom); a = 8'($urandom); b = 8'($urandom);
    x = 16'($urandom); y = 16'($urandom);
    @(negedge clk);
    start = 1'b1; page = (kind == 3); sp_in = sp; pc_in = pc;
    opcode = (kind == 0) ? 8'h3F : (kind == 1) ? 8'h3B : (kind == 2) ? 8'h39 : 8'h38;
    ccr_in = c; a_in = a; b_in = b; ix_in = x; iy_in = y;
    @(negedge clk);
    start = 1'b0;
    ccr_in = ~c; a_in = ~a; b_in = ~b; ix_in = ~x; iy_in = ~y; sp_in = ~sp; pc_in = ~pc;
    for (int k = 1; k <= n; k++) begin
      chk("R12 R3 R6 R7 R8 addr", addr, eaddr(kind, k, pc, sp));
      chk("R3 rw", {15'd0, rw}, {15'd0, !(kind == 0 && k >= 3 && k <= 11)});
      chk("R10 busy", {15'd0, busy}, 16'd1);
      if (kind == 0 && k >= 3 && k <= 11)
        chk("R4 push byte", {8'd0, wdata}, {8'd0, ewd(k, pc, c, a, b, x, y)});
      if (poke && k == 2) begin start = 1'b1; page = 1'b0; opcode = 8'h39; end
      if (poke && k == 3) start = 1'b0;
      @(negedge clk);
    end
    e_c = c; e_a = a; e_b = b; e_x = x; e_y = y;
    case (kind)
      0: begin e_sp = sp - 16'd9; e_pc = {pat(TB_VEC), pat(TB_VEC + 16'd1)}; end
      1: begin
        e_sp = sp + 16'd9;
        e_c = pat(sp + 16'd1); e_b = pat(sp + 16'd2); e_a = pat(sp + 16'd3);
        e_x = {pat(sp + 16'd4), pat(sp + 16'd5)};
        e_y = {pat(sp + 16'd6), pat(sp + 16'd7)};
        e_pc = {pat(sp + 16'd8), pat(sp + 16'd9)};
      end
      2: begin e_sp = sp + 16'd2; e_pc = {pat(sp + 16'd1), pat(sp + 16'd2)}; end
      default: begin
        e_sp = sp + 16'd2; e_pc = pc + 16'd2;
        e_y = {pat(sp + 16'd1), pat(sp + 16'd2)};
      end
    endcase
    chk("R10 done", {15'd0, done}, 16'd1);
    chk("R10 busy low", {15'd0, busy}, 16'd0);
    chk("R5 R6 R7 R8 sp_out", sp_out, e_sp);
    chk("R5 R6 R7 R8 pc_out", pc_out, e_pc);
    chk("R6 R9 ccr_out", {8'd0, ccr_out}, {8'd0, e_c});
    chk("R6 R9 a_out", {8'd0, a_out}, {8'd0, e_a});
    chk("R6 R9 b_out", {8'd0, b_out}, {8'd0, e_b});
    chk("R6 R9 ix_out", ix_out, e_x);
    chk("R6 R8 R9 iy_out", iy_out, e_y);
    chk("R1 idle addr", addr, 16'hFFFF);
    @(negedge clk);
    chk("R10 done pulse", {15'd0, done}, 16'd0);
    chk("R11 no restart", {15'd0, busy}, 16'd0);
  endtask

  task automatic bad_op(input logic pg, input logic [7:0] op);
    @(negedge clk);
    start = 1'b1; page = pg; opcode = op;
    @(negedge clk);
    start = 1'b0;
    chk("R2 err", {15'd0, err}, 16'd1);
    chk("R2 no busy", {15'd0, busy}, 16'd0);
    chk("R2 no cycle", {addr[15:1], rw}, 16'hFFFF);
    @(negedge clk);
    chk("R2 err pulse", {15'd0, err}, 16'd0);
    chk("R2 still idle", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    key = 8'($urandom);
    #(CLK_PERIOD * 2 + 2);
    chk("R1 reset busy", {15'd0, busy}, 16'd0);
    chk("R1 reset done/err", {14'd0, done, err}, 16'd0);
    chk("R1 reset bus", addr, 16'hFFFF);
    chk("R1 reset rw/wdata", {7'd0, rw, wdata}, 16'h0100);
    rst_n = 1'b1;
    run_op(0, 16'h0004, 16'h1234, 1'b0);
    run_op(1, 16'hFFFA, 16'hFFFE, 1'b0);
    run_op(2, 16'hFFFF, 16'h8000, 1'b0);
    run_op(3, 16'hFFFE, 16'hFFFF, 1'b0);
    run_op(0, 16'h4000, 16'h0100, 1'b1);
    run_op(1, 16'h2000, 16'h0200, 1'b1);
    bad_op(1'b1, 8'h3F);
    bad_op(1'b0, 8'h38);
    bad_op(1'b0, 8'h00);
    for (int i = 0; i < 40; i++)
      run_op(int'($urandom_range(0, 3)), 16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule